// File: doc/BRIEF.md
# PCI 64-bit Upper-Half Handshake Controller

This block controls the upper half of a 64-bit PCI bus on one port of a bridge. It owns the 64-bit acknowledge output for the port's target side. It also decides, cycle by cycle, who drives the upper 32 address/data pins and the upper 4 command/byte-enable pins, and with which value. Every pin is modelled as a value and output-enable pair. Pad tristating happens outside the block.

While reset is held, the block samples the bus 64-bit request line as a strap. If the request is asserted (low), the extension is enabled. The upper pins are then driven only by the transfer that owns them and are otherwise left undriven, held by pull-ups, because the bus is never parked. If the request is deasserted (high), the extension is disabled, and the upper pins are driven to a constant fill level for as long as reset stays released.

The port's transaction engine supplies the timing inputs. For the target it supplies the next value of device select and the read-data phase. For the initiator it supplies bus ownership, address or data phase, dual-address use, its own 64-bit request and the remote acknowledge. All timing inputs are active low, and each one describes the next bus cycle. Every pin output is registered, so it shows the effect of its inputs one clock later.

Top module: `wide_ext_ctrl`

## Requirements
- R1: The acknowledge asserts only at an edge where all of the following hold:
  - the extension is enabled;
  - `tgt_wide_ok` is 1;
  - `req64_n` is 0;
  - `tgt_dsel_next_n` goes from 1 to 0, which starts device select.

  A claim made without these conditions leaves `ack64_oe` at 0 for the whole claim. A later request in the same claim also leaves it at 0.
- R2: Once started, the acknowledge follows device select on the same edges. `ack64_n_o` is 0 in every cycle after an edge where `tgt_dsel_next_n` was 0, and it leaves on the edge where `tgt_dsel_next_n` returns to 1.
- R3: On release, `ack64_n_o` is 1 with `ack64_oe` at 1 for exactly one cycle, and then `ack64_oe` is 0. A new claim may start a fresh acknowledge directly from that release cycle.
- R4: While `rst_n` is 0, and for the first `RST_STAGES` rising edges after it rises, `ad_hi_oe`, `cbe_hi_oe` and `ack64_oe` are 0, and the value outputs hold the fill level.
- R5: `req64_n` is sampled on every rising edge while reset is in effect, and the last sample decides the mode. When that sample is 1 (disabled), `ad_hi_oe` and `cbe_hi_oe` are held at 1 with every bit at the fill level, and the acknowledge is never driven, whatever the other inputs do.
- R6: With the extension enabled and neither the port's initiator nor a 64-bit target read owning the upper pins, both upper enables are 0 and the values sit at the fill level.
- R7: In an initiator address phase (`ini_own_n`=0, `ini_addr_n`=0), both enables are 1. With `ini_dac`=1 and `ini_req64_n`=0, `ad_hi_o` carries `ini_addr_hi` and `cbe_hi_o` carries `ini_cmd`. Otherwise both carry the fill level.
- R8: In an initiator data phase (`ini_own_n`=0, `ini_addr_n`=1), a wide transfer is one with `ini_req64_n`=0 and `ini_ack64_n`=0.
  - In a wide transfer, `cbe_hi_o` carries `ini_be_n`.
  - In a wide write (`ini_write`=1), `ad_hi_o` carries `ini_wdata_hi`.
  - In a wide read, `ad_hi_oe` is 0.
  - In a transfer that is not wide, both enables are 1 and both values are at the fill level.
- R9: When the port's initiator does not own the bus, `tgt_rd_n`=0 and the acknowledge is asserted in the same cycle, the target drives `ad_hi_o` with `tgt_rdata_hi` (`ad_hi_oe`=1) and leaves `cbe_hi_oe` at 0. The port's initiator takes priority over the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req64_n | input | 1 | Bus 64-bit request line (strap during reset, remote initiator request afterwards) |
| tgt_dsel_next_n | input | 1 | Target's device select for the next cycle, active low |
| tgt_wide_ok | input | 1 | Target can accept this claim 64 bits wide |
| tgt_rd_n | input | 1 | Target drives read data next cycle, active low |
| tgt_rdata_hi | input | HI_W | Upper read data from the target |
| ini_own_n | input | 1 | Port's initiator owns the bus next cycle, active low |
| ini_addr_n | input | 1 | Next cycle is an address phase, active low |
| ini_dac | input | 1 | Address phase uses the dual-address command |
| ini_req64_n | input | 1 | Port's initiator requests 64-bit transfer, active low |
| ini_ack64_n | input | 1 | Remote target's 64-bit acknowledge, active low |
| ini_write | input | 1 | Initiator transfer is a write |
| ini_addr_hi | input | HI_W | Upper 32 address bits |
| ini_cmd | input | BE_W | Command for the upper command pins |
| ini_be_n | input | BE_W | Upper byte enables, active low |
| ini_wdata_hi | input | HI_W | Upper write data |
| ack64_n_o | output | 1 | 64-bit acknowledge value |
| ack64_oe | output | 1 | 64-bit acknowledge output enable |
| ad_hi_o | output | HI_W | Upper address/data value |
| ad_hi_oe | output | 1 | Upper address/data output enable |
| cbe_hi_o | output | BE_W | Upper command/byte-enable value |
| cbe_hi_oe | output | 1 | Upper command/byte-enable output enable |

## Verification
The bench builds the block with its defaults: `HI_W`=32, `BE_W`=4, `RST_STAGES`=2, fill level all ones. These defaults put the full-width address and data patterns on the pins, so a lane swap or a fill leak shows in any bit. The two-stage reset release opens a window in which the strap is still sampled but the outputs stay off. The bench resets twice, once with each strap level, which covers both modes and the change between them within one run.

// File: rtl/ext64_pkg.sv
package ext64_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_ON   = 2'd1,
    ACK_REL  = 2'd2
  } ack_st_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_INIT  = 2'd1,
    SRC_TGT   = 2'd2,
    SRC_STRAP = 2'd3
  } drv_src_e;
endpackage

// File: rtl/ext64_rst_sync.sv
module ext64_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic run
);
  generate
    if (STAGES <= 1) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= 1'b0;
        else         q <= 1'b1;
      end
      assign run = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= '0;
        else         sh <= {sh[STAGES-2:0], 1'b1};
      end
      assign run = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ext64_strap.sv
module ext64_strap (
  input  logic clk,
  input  logic run,
  input  logic req64_n,
  output logic ext_en
);
  logic en_q;
  logic en_d;
  logic cap;

  always_comb begin
    cap  = ~run;
    en_d = cap ? ~req64_n : en_q;
  end

  always_ff @(posedge clk) begin
    en_q <= en_d;
  end

  assign ext_en = en_q;
endmodule

// File: rtl/ext64_ack_gen.sv
module ext64_ack_gen
  import ext64_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  input  logic ext_en,
  input  logic dsel_next_n,
  input  logic req64_n,
  input  logic wide_ok,
  output logic ack_n,
  output logic ack_oe,
  output logic ack_on_next
);
  ack_st_e st_q, st_d;
  logic    dsel_q, dsel_d;
  logic    start;

  always_comb begin
    start = ext_en & dsel_q & ~dsel_next_n & ~req64_n & wide_ok;
    unique case (st_q)
      ACK_IDLE: st_d = start ? ACK_ON : ACK_IDLE;
      ACK_ON:   st_d = dsel_next_n ? ACK_REL : ACK_ON;
      ACK_REL:  st_d = start ? ACK_ON : ACK_IDLE;
      default:  st_d = ACK_IDLE;
    endcase
    if (!run) st_d = ACK_IDLE;
    dsel_d = run ? dsel_next_n : 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= ACK_IDLE;
      dsel_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      dsel_q <= dsel_d;
    end
  end

  assign ack_n       = (st_q != ACK_ON);
  assign ack_oe      = (st_q != ACK_IDLE);
  assign ack_on_next = (st_d == ACK_ON);
endmodule

// File: rtl/ext64_hi_driver.sv
module ext64_hi_driver
  import ext64_pkg::*;
#(
  parameter int   HI_W = 32,
  parameter int   BE_W = 4,
  parameter logic FILL = 1'b1
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            run,
  input  logic            ext_en,
  input  logic            ini_own_n,
  input  logic            ini_addr_n,
  input  logic            ini_dac,
  input  logic            ini_req64_n,
  input  logic            ini_ack64_n,
  input  logic            ini_write,
  input  logic [HI_W-1:0] ini_addr_hi,
  input  logic [BE_W-1:0] ini_cmd,
  input  logic [BE_W-1:0] ini_be_n,
  input  logic [HI_W-1:0] ini_wdata_hi,
  input  logic            tgt_on_next,
  input  logic            tgt_rd_n,
  input  logic [HI_W-1:0] tgt_rdata_hi,
  output logic [HI_W-1:0] ad_o,
  output logic            ad_oe,
  output logic [BE_W-1:0] cbe_o,
  output logic            cbe_oe
);
  localparam logic [HI_W-1:0] AD_FILL  = {HI_W{FILL}};
  localparam logic [BE_W-1:0] CBE_FILL = {BE_W{FILL}};

  drv_src_e        src;
  logic            wide, dac_addr;
  logic [HI_W-1:0] ad_d, ad_q;
  logic [BE_W-1:0] cbe_d, cbe_q;
  logic            ad_oe_d, ad_oe_q, cbe_oe_d, cbe_oe_q;

  always_comb begin
    if (!ext_en)                       src = SRC_STRAP;
    else if (!ini_own_n)               src = SRC_INIT;
    else if (tgt_on_next && !tgt_rd_n) src = SRC_TGT;
    else                               src = SRC_NONE;
  end

  always_comb begin
    wide     = ~ini_req64_n & ~ini_ack64_n;
    dac_addr = ini_dac & ~ini_req64_n;
    ad_d     = AD_FILL;
    cbe_d    = CBE_FILL;
    ad_oe_d  = 1'b0;
    cbe_oe_d = 1'b0;
    unique case (src)
      SRC_STRAP: begin
        ad_oe_d  = 1'b1;
        cbe_oe_d = 1'b1;
      end
      SRC_INIT: begin
        ad_oe_d  = 1'b1;
        cbe_oe_d = 1'b1;
        if (!ini_addr_n) begin
          if (dac_addr) begin
            ad_d  = ini_addr_hi;
            cbe_d = ini_cmd;
          end
        end else if (wide) begin
          cbe_d = ini_be_n;
          if (ini_write) ad_d    = ini_wdata_hi;
          else           ad_oe_d = 1'b0;
        end
      end
      SRC_TGT: begin
        ad_oe_d = 1'b1;
        ad_d    = tgt_rdata_hi;
      end
      default: begin
        ad_oe_d  = 1'b0;
        cbe_oe_d = 1'b0;
      end
    endcase
    if (!run) begin
      ad_d     = AD_FILL;
      cbe_d    = CBE_FILL;
      ad_oe_d  = 1'b0;
      cbe_oe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ad_q     <= AD_FILL;
      cbe_q    <= CBE_FILL;
      ad_oe_q  <= 1'b0;
      cbe_oe_q <= 1'b0;
    end else begin
      ad_q     <= ad_d;
      cbe_q    <= cbe_d;
      ad_oe_q  <= ad_oe_d;
      cbe_oe_q <= cbe_oe_d;
    end
  end

  assign ad_o   = ad_q;
  assign ad_oe  = ad_oe_q;
  assign cbe_o  = cbe_q;
  assign cbe_oe = cbe_oe_q;
endmodule

// File: rtl/wide_ext_ctrl.sv
module wide_ext_ctrl #(
  parameter int   HI_W       = 32,
  parameter int   BE_W       = 4,
  parameter int   RST_STAGES = 2,
  parameter logic FILL       = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req64_n,
  input  logic            tgt_dsel_next_n,
  input  logic            tgt_wide_ok,
  input  logic            tgt_rd_n,
  input  logic [HI_W-1:0] tgt_rdata_hi,
  input  logic            ini_own_n,
  input  logic            ini_addr_n,
  input  logic            ini_dac,
  input  logic            ini_req64_n,
  input  logic            ini_ack64_n,
  input  logic            ini_write,
  input  logic [HI_W-1:0] ini_addr_hi,
  input  logic [BE_W-1:0] ini_cmd,
  input  logic [BE_W-1:0] ini_be_n,
  input  logic [HI_W-1:0] ini_wdata_hi,
  output logic            ack64_n_o,
  output logic            ack64_oe,
  output logic [HI_W-1:0] ad_hi_o,
  output logic            ad_hi_oe,
  output logic [BE_W-1:0] cbe_hi_o,
  output logic            cbe_hi_oe
);
  logic run;
  logic ext_en;
  logic ack_on_next;

  ext64_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .run(run)
  );

  ext64_strap u_strap (
    .clk(clk), .run(run), .req64_n(req64_n), .ext_en(ext_en)
  );

  ext64_ack_gen u_ack (
    .clk(clk), .arst_n(rst_n), .run(run), .ext_en(ext_en),
    .dsel_next_n(tgt_dsel_next_n), .req64_n(req64_n), .wide_ok(tgt_wide_ok),
    .ack_n(ack64_n_o), .ack_oe(ack64_oe), .ack_on_next(ack_on_next)
  );

  ext64_hi_driver #(.HI_W(HI_W), .BE_W(BE_W), .FILL(FILL)) u_drv (
    .clk(clk), .arst_n(rst_n), .run(run), .ext_en(ext_en),
    .ini_own_n(ini_own_n), .ini_addr_n(ini_addr_n), .ini_dac(ini_dac),
    .ini_req64_n(ini_req64_n), .ini_ack64_n(ini_ack64_n), .ini_write(ini_write),
    .ini_addr_hi(ini_addr_hi), .ini_cmd(ini_cmd), .ini_be_n(ini_be_n),
    .ini_wdata_hi(ini_wdata_hi), .tgt_on_next(ack_on_next), .tgt_rd_n(tgt_rd_n),
    .tgt_rdata_hi(tgt_rdata_hi), .ad_o(ad_hi_o), .ad_oe(ad_hi_oe),
    .cbe_o(cbe_hi_o), .cbe_oe(cbe_hi_oe)
  );
endmodule

// File: rtl/wide_ext_ctrl_chk.sv
module wide_ext_ctrl_chk #(
  parameter int   HI_W = 32,
  parameter logic FILL = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            ext_en,
  input logic            req64_n,
  input logic            tgt_dsel_next_n,
  input logic            ini_own_n,
  input logic            ini_addr_n,
  input logic            ini_req64_n,
  input logic            ini_ack64_n,
  input logic            ini_write,
  input logic            ack64_n_o,
  input logic            ack64_oe,
  input logic [HI_W-1:0] ad_hi_o,
  input logic            ad_hi_oe,
  input logic            cbe_hi_oe
);
  logic ack_on;
  assign ack_on = ack64_oe & ~ack64_n_o;

  // R4: enables off while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r4_oe_off_in_reset: assert (!ad_hi_oe && !cbe_hi_oe && !ack64_oe)
        else $error("R4 enable active in reset");
    end
  end

  // R1: acknowledge only starts with the bus request asserted
  a_r1_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_on && !$past(ack_on)) |-> !$past(req64_n));

  // R2: acknowledge asserted only after an asserted device select
  a_r2_ack_tracks_dsel: assert property (@(posedge clk) disable iff (!rst_n)
    ack_on |-> !$past(tgt_dsel_next_n));

  // R3: release drives high for one cycle, then the enable drops
  a_r3_release_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_on && tgt_dsel_next_n) |=> (ack64_oe && ack64_n_o));
  a_r3_release_once: assert property (@(posedge clk) disable iff (!rst_n)
    (ack64_oe && ack64_n_o) |=> !(ack64_oe && ack64_n_o));

  // R5: disabled extension keeps the upper pins driven at the fill level
  a_r5_disabled_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !ext_en) |->
      (ad_hi_oe && cbe_hi_oe && ad_hi_o == {HI_W{FILL}} && !ack64_oe));

  // R8: wide initiator read leaves the upper data to the target
  a_r8_wide_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run && ext_en && !ini_own_n && ini_addr_n && !ini_req64_n &&
           !ini_ack64_n && !ini_write)) |-> !ad_hi_oe);

  // R9: target drives upper data only while acknowledging
  a_r9_tgt_data_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_hi_oe && ext_en && $past(run) && $past(ini_own_n)) |-> ack_on);
endmodule

bind wide_ext_ctrl wide_ext_ctrl_chk #(.HI_W(HI_W), .FILL(FILL)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .ext_en(ext_en), .req64_n(req64_n),
  .tgt_dsel_next_n(tgt_dsel_next_n), .ini_own_n(ini_own_n),
  .ini_addr_n(ini_addr_n), .ini_req64_n(ini_req64_n),
  .ini_ack64_n(ini_ack64_n), .ini_write(ini_write),
  .ack64_n_o(ack64_n_o), .ack64_oe(ack64_oe), .ad_hi_o(ad_hi_o),
  .ad_hi_oe(ad_hi_oe), .cbe_hi_oe(cbe_hi_oe)
);

// File: tb/sim_wide_ext_ctrl.sv
`timescale 1ns/1ps
module sim_wide_ext_ctrl;
  localparam int HI_W = 32;
  localparam int BE_W = 4;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req64_n, dsel_n, wide_ok, rd_n;
  logic [HI_W-1:0] rdata, addr_hi, wdata;
  logic own_n, addr_n, dac, ireq_n, iack_n, wr;
  logic [BE_W-1:0] cmd, be_n;
  logic ack_n, ack_oe, ad_oe, cbe_oe;
  logic [HI_W-1:0] ad;
  logic [BE_W-1:0] cbe;

  wide_ext_ctrl #(.HI_W(HI_W), .BE_W(BE_W), .RST_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .req64_n(req64_n), .tgt_dsel_next_n(dsel_n),
    .tgt_wide_ok(wide_ok), .tgt_rd_n(rd_n), .tgt_rdata_hi(rdata),
    .ini_own_n(own_n), .ini_addr_n(addr_n), .ini_dac(dac),
    .ini_req64_n(ireq_n), .ini_ack64_n(iack_n), .ini_write(wr),
    .ini_addr_hi(addr_hi), .ini_cmd(cmd), .ini_be_n(be_n),
    .ini_wdata_hi(wdata), .ack64_n_o(ack_n), .ack64_oe(ack_oe),
    .ad_hi_o(ad), .ad_hi_oe(ad_oe), .cbe_hi_o(cbe), .cbe_hi_oe(cbe_oe)
  );

  // behavioural reference
  integer rcnt, ackst;
  logic strap, pdsel;
  logic e_ackn, e_ackoe, e_adoe, e_cbeoe;
  logic [HI_W-1:0] e_ad;
  logic [BE_W-1:0] e_cbe;

  task automatic ref_off();
    e_ackn = 1'b1; e_ackoe = 1'b0; e_adoe = 1'b0; e_cbeoe = 1'b0;
    e_ad = '1; e_cbe = '1; ackst = 0; pdsel = 1'b1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0; strap = ~req64_n; ref_off();
    end else if (rcnt < SYNC) begin
      rcnt = rcnt + 1; strap = ~req64_n; ref_off();
    end else begin
      automatic bit start = strap && pdsel && !dsel_n && !req64_n && wide_ok;
      automatic integer nst;
      if (ackst == 1) nst = dsel_n ? 2 : 1;
      else            nst = start ? 1 : 0;
      ackst = nst; pdsel = dsel_n;
      e_ackn = (nst != 1); e_ackoe = (nst != 0);
      e_ad = '1; e_cbe = '1; e_adoe = 1'b0; e_cbeoe = 1'b0;
      if (!strap) begin
        e_adoe = 1'b1; e_cbeoe = 1'b1;
      end else if (!own_n) begin
        e_adoe = 1'b1; e_cbeoe = 1'b1;
        if (!addr_n) begin
          if (dac && !ireq_n) begin e_ad = addr_hi; e_cbe = cmd; end
        end else if (!ireq_n && !iack_n) begin
          e_cbe = be_n;
          if (wr) e_ad = wdata; else e_adoe = 1'b0;
        end
      end else if (nst == 1 && !rd_n) begin
        e_adoe = 1'b1; e_ad = rdata;
      end
    end
  end

  integer tests = 0, fails = 0;
  string  tag = "R4";
  bit     done = 1'b0;

  task automatic cmp(string f, logic [63:0] a, logic [63:0] e);
    tests = tests + 1;
    if (a !== e) begin
      fails = fails + 1;
      $display("FAIL %s %s act=%h exp=%h", tag, f, a, e);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp("ack_n", 64'(ack_n), 64'(e_ackn));
    cmp("ack_oe", 64'(ack_oe), 64'(e_ackoe));
    cmp("ad", 64'(ad), 64'(e_ad));
    cmp("ad_oe", 64'(ad_oe), 64'(e_adoe));
    cmp("cbe", 64'(cbe), 64'(e_cbe));
    cmp("cbe_oe", 64'(cbe_oe), 64'(e_cbeoe));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails = fails + 1; tests = tests + 1;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req64_n = 0; dsel_n = 1; wide_ok = 1; rd_n = 1;
    rdata = 32'h0; addr_hi = 32'h0; wdata = 32'h0;
    own_n = 1; addr_n = 1; dac = 0; ireq_n = 1; iack_n = 1; wr = 0;
    cmd = 4'h0; be_n = 4'hF;
    // R4: reset state, strap enabled
    tag = "R4"; ticks(3);
    rst_n = 1; ticks(SYNC);
    req64_n = 1;
    // R6: enabled, nobody owns the upper pins
    tag = "R6"; ticks(3);
    // R9: 64-bit target read
    tag = "R9"; req64_n = 0; dsel_n = 0; tick();
    rd_n = 0; rdata = 32'hA5A5_0F0F; tick();
    rdata = 32'h1234_5678; tick();
    rdata = 32'hDEAD_BEEF; tick();
    rd_n = 1; tick();
    // R3: release cycle and then undriven
    tag = "R3"; dsel_n = 1; req64_n = 1; ticks(3);
    // R2: two back-to-back claims
    tag = "R2"; req64_n = 0; dsel_n = 0; ticks(2);
    dsel_n = 1; tick();
    dsel_n = 0; ticks(2);
    dsel_n = 1; req64_n = 1; ticks(3);
    // R1: claim without request, late request, not wide
    tag = "R1"; dsel_n = 0; rd_n = 0; ticks(3);
    req64_n = 0; ticks(2);
    dsel_n = 1; ticks(2);
    wide_ok = 0; dsel_n = 0; ticks(3);
    dsel_n = 1; wide_ok = 1; rd_n = 1; req64_n = 1; ticks(2);
    // R7: initiator address phases
    tag = "R7"; own_n = 0; addr_n = 0; dac = 1; ireq_n = 0;
    addr_hi = 32'h0000_00C3; cmd = 4'h6; tick();
    dac = 0; tick();
    dac = 1; ireq_n = 1; tick();
    // R8: initiator data phases
    tag = "R8"; addr_n = 1; ireq_n = 0; iack_n = 0; wr = 1;
    be_n = 4'h0; wdata = 32'h5555_AAAA; tick();
    be_n = 4'hA; wdata = 32'h0000_0001; tick();
    wr = 0; be_n = 4'h3; tick();
    iack_n = 1; tick();
    ireq_n = 1; iack_n = 0; tick();
    // R9: initiator has priority over a target read
    tag = "R9"; iack_n = 1; req64_n = 0; dsel_n = 0; rd_n = 0;
    rdata = 32'hFEED_0001; ticks(2);
    own_n = 1; ticks(2);
    dsel_n = 1; rd_n = 1; req64_n = 1; ticks(3);
    // R5: reset with strap disabled
    tag = "R4"; rst_n = 0; req64_n = 1; ticks(2);
    rst_n = 1; ticks(SYNC);
    tag = "R5"; tick();
    dsel_n = 0; req64_n = 0; rd_n = 0; ticks(3);
    dsel_n = 1; rd_n = 1; own_n = 0; addr_n = 0; dac = 1; ireq_n = 0; ticks(2);
    own_n = 1; addr_n = 1; ireq_n = 1; req64_n = 1; ticks(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule